// File: doc/BRIEF.md
# Ticket Lock Unit

This block hands out mutual exclusion to a handful of requesters in strict first-come order. Each lock instance keeps two 8-bit counters: the number of the next ticket to give out and the number of the ticket currently allowed in. When a requester raises its acquire strobe, it draws a ticket straight away. The draw is an atomic fetch-and-increment of the next-ticket counter. The requester then sees its grant line rise once the now-serving counter reaches its ticket. Raising the release strobe advances now-serving by one, and the next ticket in line is admitted.

Each requester selects one of several independent lock instances through its lock index. A requester holds at most one ticket at a time. Several requesters may arrive in the same cycle, and the unit gives them consecutive tickets by fixed port priority. A release from a requester that is not currently admitted changes nothing and is reported on a one-cycle error line.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset every lock's next-ticket and now-serving counters are zero, no requester is pending or granted, and the first acquire on a lock receives ticket 0 and is granted in the cycle after the acquire.
- R2: A requester with no ticket that asserts acqReq receives the selected lock's next-ticket value on `ticket` and has `pending` high from the cycle after, and that lock's next-ticket advances.
- R3: `granted` for a requester is high exactly when it is pending and its ticket equals the now-serving value of its lock, so at most one requester per lock is granted.
- R4: A release from the granted requester advances its lock's now-serving value by one and clears its `pending`, and the grant moves to the holder of the following ticket in the next cycle.
- R5: Grants on a lock are given in the order in which the acquires arrived.
- R6: Acquires to one lock in the same cycle are ordered by port index, the lowest index first, and get consecutive tickets.
- R7: Ticket values are 8 bits wide and wrap from 255 to 0 without disturbing the order; fewer than 256 tickets per lock are ever outstanding.
- R8: A release from a requester that is not granted leaves every counter and grant unchanged, and it raises that requester's `relError` for exactly the following cycle.
- R9: Lock instances are independent: a grant on one lock has no effect on the counters or grants of another.
- R10: An acquire from a requester that already holds a ticket is ignored: its ticket does not change and no ticket is drawn.
- R11: A release and an acquire on the same lock in the same cycle both take effect. The new arrival draws from next-ticket, and now-serving advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| acqReq | input | REQS | Per-requester acquire strobe |
| relReq | input | REQS | Per-requester release strobe |
| lockSel | input | REQS*SEL_W | Per-requester lock index used by an acquire, requester r in bits [r*SEL_W +: SEL_W] |
| granted | output | REQS | Requester currently holds its lock |
| pending | output | REQS | Requester holds a ticket (waiting or granted) |
| ticket | output | REQS*CNT_W | Ticket held by requester r in bits [r*CNT_W +: CNT_W] |
| relError | output | REQS | One-cycle pulse after a release by a requester that was not granted |

## Verification
The interesting overlap is an admission and a new arrival on the same lock in one edge. The holder's release advances now-serving while another requester's acquire draws from next-ticket, and two same-cycle arrivals must each take a distinct ticket. Directed steps provoke both cases. A randomized run then keeps releasing holders and acquiring for thousands of cycles, long enough to wrap the counters. A cycle-level model in the bench predicts every grant, pending flag and error pulse after each edge, and a scoreboard queue matches each freshly issued ticket against the value the model drew.

// File: rtl/tkl_pkg.sv
package tkl_pkg;
  localparam int REQS  = 4;
  localparam int LOCKS = 2;
  localparam int CNT_W = 8;
  localparam int SEL_W = (LOCKS > 1) ? $clog2(LOCKS) : 1;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [SEL_W-1:0] sel_t;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic [REQS-1:0]             issue;      // requester draws a ticket
    logic [REQS-1:0][CNT_W-1:0]  rank;       // offset among same-lock arrivals
    logic [LOCKS-1:0][CNT_W-1:0] nextBump;   // tickets drawn per lock
    logic [LOCKS-1:0]            serveBump;  // valid release per lock
    logic [REQS-1:0]             drop;       // requester gives up its ticket
    logic [REQS-1:0]             relErr;     // release from a non-holder
  } strobe_t;
endpackage

// File: rtl/tkl_ctrl.sv
module tkl_ctrl
  import tkl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REQS-1:0]       acqReq,
  input  logic [REQS-1:0]       relReq,
  input  sel_t [REQS-1:0]       lockSel,
  input  logic [REQS-1:0]       pending,
  input  logic [REQS-1:0]       granted,
  input  sel_t [REQS-1:0]       heldLock,
  output strobe_t               strb
);
  logic [LOCKS-1:0][REQS-1:0] dropOnLock;

  always_comb begin
    cnt_t k;
    strb = '0;
    dropOnLock = '0;
    for (int r = 0; r < REQS; r++) begin
      strb.issue[r]  = acqReq[r] & ~pending[r];
      strb.drop[r]   = relReq[r] & granted[r];
      strb.relErr[r] = relReq[r] & ~granted[r];
    end
    // fixed port priority among same-cycle arrivals to one lock
    for (int r = 0; r < REQS; r++) begin
      k = '0;
      for (int q = 0; q < r; q++) begin
        if (strb.issue[q] && lockSel[q] == lockSel[r]) k = k + cnt_t'(1);
      end
      strb.rank[r] = k;
    end
    for (int l = 0; l < LOCKS; l++) begin
      for (int r = 0; r < REQS; r++) begin
        if (strb.issue[r] && lockSel[r] == sel_t'(l))
          strb.nextBump[l] = strb.nextBump[l] + cnt_t'(1);
        if (strb.drop[r] && heldLock[r] == sel_t'(l)) begin
          dropOnLock[l][r]  = 1'b1;
          strb.serveBump[l] = 1'b1;
        end
      end
    end
  end

  generate
    for (genvar l = 0; l < LOCKS; l++) begin : g_relChk
      AST_ONE_RELEASE_PER_LOCK: assert property (@(posedge clk) disable iff (!rstN)
        $countones(dropOnLock[l]) <= 1); // R3
    end
  endgenerate
endmodule

// File: rtl/tkl_datapath.sv
module tkl_datapath
  import tkl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  sel_t [REQS-1:0]       lockSel,
  output logic [REQS-1:0]       pending,
  output logic [REQS-1:0]       granted,
  output sel_t [REQS-1:0]       heldLock,
  output cnt_t [REQS-1:0]       ticketReg,
  output logic [REQS-1:0]       relError
);
  cnt_t [LOCKS-1:0] nextTicket;
  cnt_t [LOCKS-1:0] nowServing;
  logic [LOCKS-1:0][REQS-1:0] grantOnLock;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextTicket <= '0;
      nowServing <= '0;
      pending    <= '0;
      heldLock   <= '0;
      ticketReg  <= '0;
      relError   <= '0;
    end else begin
      for (int l = 0; l < LOCKS; l++) begin
        nextTicket[l] <= nextTicket[l] + strb.nextBump[l];
        nowServing[l] <= nowServing[l] + cnt_t'(strb.serveBump[l]);
      end
      for (int r = 0; r < REQS; r++) begin
        if (strb.issue[r]) begin
          ticketReg[r] <= nextTicket[lockSel[r]] + strb.rank[r];
          heldLock[r]  <= lockSel[r];
          pending[r]   <= 1'b1;
        end else if (strb.drop[r]) begin
          pending[r]   <= 1'b0;
        end
      end
      relError <= strb.relErr;
    end
  end

  always_comb begin
    grantOnLock = '0;
    for (int r = 0; r < REQS; r++) begin
      granted[r] = pending[r] && (nowServing[heldLock[r]] == ticketReg[r]);
      for (int l = 0; l < LOCKS; l++)
        grantOnLock[l][r] = granted[r] && heldLock[r] == sel_t'(l);
    end
  end

  generate
    for (genvar l = 0; l < LOCKS; l++) begin : g_lockChk
      AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(grantOnLock[l])); // R3
      AST_SERVE_STEP: assert property (@(posedge clk) disable iff (!rstN)
        (nowServing[l] != $past(nowServing[l])) |->
          (nowServing[l] == $past(nowServing[l]) + cnt_t'(1))); // R4
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
        cnt_t'(nextTicket[l] - nowServing[l]) <= cnt_t'(REQS)); // R7
    end
  endgenerate
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit
  import tkl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [REQS-1:0]         acqReq,
  input  logic [REQS-1:0]         relReq,
  input  logic [REQS*SEL_W-1:0]   lockSel,
  output logic [REQS-1:0]         granted,
  output logic [REQS-1:0]         pending,
  output logic [REQS*CNT_W-1:0]   ticket,
  output logic [REQS-1:0]         relError
);
  sel_t [REQS-1:0] selArr;
  sel_t [REQS-1:0] heldLock;
  cnt_t [REQS-1:0] ticketReg;
  strobe_t         strb;

  assign selArr = lockSel;
  assign ticket = ticketReg;

  tkl_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .acqReq   (acqReq),
    .relReq   (relReq),
    .lockSel  (selArr),
    .pending  (pending),
    .granted  (granted),
    .heldLock (heldLock),
    .strb     (strb)
  );

  tkl_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .lockSel   (selArr),
    .pending   (pending),
    .granted   (granted),
    .heldLock  (heldLock),
    .ticketReg (ticketReg),
    .relError  (relError)
  );

  generate
    for (genvar r = 0; r < REQS; r++) begin : g_portChk
      AST_ACQ_PENDING: assert property (@(posedge clk) disable iff (!rstN)
        (acqReq[r] && !pending[r]) |=> pending[r]); // R2
      AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rstN)
        (relReq[r] && granted[r]) |=> !pending[r]); // R4
      AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
        relError[r] |-> ($past(relReq[r]) && !$past(granted[r]))); // R8
    end
  endgenerate
endmodule

// File: tb/tb_ticket_lock_unit.sv
`timescale 1ns/1ps
module tb_ticket_lock_unit;
  import tkl_pkg::*;

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [REQS-1:0]       acqReq = '0;
  logic [REQS-1:0]       relReq = '0;
  logic [REQS*SEL_W-1:0] lockSel = '0;
  logic [REQS-1:0]       granted, pending, relError;
  logic [REQS*CNT_W-1:0] ticket;

  always #2.5 clk = ~clk;

  ticket_lock_unit dut (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .relReq(relReq),
    .lockSel(lockSel), .granted(granted), .pending(pending),
    .ticket(ticket), .relError(relError)
  );

  typedef struct { int req; int tick; bit wrap; } item_t;
  item_t sbq[$];

  int nChecks = 0;
  int nFail   = 0;
  int wrapChecks = 0;
  bit done = 1'b0;

  int mNext[LOCKS];
  int mServe[LOCKS];
  int mIssued[LOCKS];
  int mTick[REQS];
  int mLock[REQS];
  bit mPend[REQS];
  bit mErr[REQS];

  task automatic check(input string tag, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit mGrant(input int r);
    return mPend[r] && (mTick[r] == mServe[mLock[r]]);
  endfunction

  function automatic int tickOf(input int r);
    return int'(ticket[r*CNT_W +: CNT_W]);
  endfunction

  // driver: called at a falling edge, applies one cycle of stimulus
  task automatic step(input logic [REQS-1:0] acq, input logic [REQS-1:0] rel,
                      input logic [REQS-1:0][SEL_W-1:0] sv);
    bit oldPend[REQS];
    bit oldGrant[REQS];
    item_t it;
    acqReq  = acq;
    relReq  = rel;
    lockSel = sv;
    for (int r = 0; r < REQS; r++) begin
      oldPend[r]  = mPend[r];
      oldGrant[r] = mGrant(r);
    end
    for (int r = 0; r < REQS; r++) begin
      mErr[r] = rel[r] && !oldGrant[r];
      if (rel[r] && oldGrant[r]) begin
        mServe[mLock[r]] = (mServe[mLock[r]] + 1) % 256;
        mPend[r] = 1'b0;
      end
    end
    for (int r = 0; r < REQS; r++) begin
      if (acq[r] && !oldPend[r]) begin
        mLock[r] = int'(sv[r]);
        mTick[r] = mNext[mLock[r]];
        mNext[mLock[r]] = (mNext[mLock[r]] + 1) % 256;
        mPend[r] = 1'b1;
        it.req  = r;
        it.tick = mTick[r];
        it.wrap = (mTick[r] == 0) && (mIssued[mLock[r]] > 0);
        mIssued[mLock[r]]++;
        sbq.push_back(it);
      end
    end
    @(posedge clk);
    @(negedge clk);
    for (int r = 0; r < REQS; r++) begin
      check("R3", int'(granted[r]), int'(mGrant(r)), $sformatf("granted[%0d]", r));
      check("R2", int'(pending[r]), int'(mPend[r]), $sformatf("pending[%0d]", r));
      check("R8", int'(relError[r]), int'(mErr[r]), $sformatf("relError[%0d]", r));
    end
    acqReq = '0;
    relReq = '0;
  endtask

  // monitor: compares each freshly issued ticket with the scoreboard
  bit prevPend[REQS];
  always @(negedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < REQS; r++) prevPend[r] = 1'b0;
    end else begin
      for (int r = 0; r < REQS; r++) begin
        if (pending[r] && !prevPend[r]) begin
          if (sbq.size() == 0) begin
            check("R2", 1, 0, $sformatf("unexpected ticket issue to requester %0d", r));
          end else begin
            item_t it;
            it = sbq.pop_front();
            check("R5", r, it.req, "issue order requester");
            if (it.wrap) begin
              wrapChecks++;
              check("R7", tickOf(r), it.tick, "ticket after wrap");
            end else begin
              check("R6", tickOf(r), it.tick, "issued ticket value");
            end
          end
        end
        prevPend[r] = pending[r];
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [REQS-1:0][SEL_W-1:0] s0;
    logic [REQS-1:0][SEL_W-1:0] s1;
    logic [REQS-1:0][SEL_W-1:0] sr;
    logic [REQS-1:0] aR, rR;
    s0 = '0;
    for (int r = 0; r < REQS; r++) s1[r] = SEL_W'(1);
    for (int l = 0; l < LOCKS; l++) begin mNext[l] = 0; mServe[l] = 0; mIssued[l] = 0; end
    for (int r = 0; r < REQS; r++) begin mTick[r] = 0; mLock[r] = 0; mPend[r] = 0; mErr[r] = 0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1", int'(granted), 0, "granted after reset");
    check("R1", int'(pending), 0, "pending after reset");
    check("R1", int'(relError), 0, "relError after reset");

    step(4'b0001, '0, s0);
    check("R1", int'(granted[0]), 1, "first acquire granted");
    check("R1", tickOf(0), 0, "first ticket");
    step(4'b0010, '0, s0);
    step(4'b0100, '0, s0);
    check("R5", int'(granted[1]), 0, "second arrival waits");

    step('0, 4'b0010, s0);
    check("R8", int'(relError[1]), 1, "non-holder release flagged");
    check("R8", int'(granted[0]), 1, "holder unaffected by bad release");

    step(4'b0010, '0, s0);
    check("R10", tickOf(1), 1, "ticket kept on repeated acquire");

    step('0, 4'b0001, s0);
    check("R4", int'(granted[1]), 1, "grant passes to next ticket");
    check("R4", int'(pending[0]), 0, "releaser leaves");

    step(4'b1001, '0, s0);
    check("R6", tickOf(0), 3, "lower port first");
    check("R6", tickOf(3), 4, "higher port next");

    step('0, 4'b0010, s0);
    check("R5", int'(granted[2]), 1, "third arrival admitted");
    step('0, 4'b0100, s0);
    check("R5", int'(granted[0]), 1, "fourth arrival admitted");

    step(4'b0010, '0, s1);
    check("R9", int'(granted[1]), 1, "other lock free");
    check("R9", int'(granted[0]), 1, "first lock still held");
    check("R9", tickOf(1), 0, "other lock first ticket");

    step(4'b0100, 4'b0010, s1);
    check("R11", tickOf(2), 1, "arrival during release draws next");
    check("R11", int'(granted[2]), 1, "arrival admitted by same-cycle release");

    for (int i = 0; i < 3000; i++) begin
      for (int r = 0; r < REQS; r++) begin
        aR[r] = ($urandom % 2) == 0;
        rR[r] = mGrant(r) ? (($urandom % 3) != 0) : (($urandom % 8) == 0);
        sr[r] = SEL_W'($urandom_range(LOCKS - 1, 0));
      end
      step(aR, rR, sr);
    end
    check("R7", int'(wrapChecks > 0), 1, "wrap exercised");

    for (int i = 0; i < 40; i++) begin
      for (int r = 0; r < REQS; r++) rR[r] = mGrant(r);
      step('0, rR, s0);
    end
    check("R4", int'(pending), 0, "all tickets drained");
    check("R5", sbq.size(), 0, "scoreboard empty");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule